// File: doc/BRIEF.md
# Dual-Clock FIFO Queue with Selectable Flag Timing

This block is a first-in first-out queue whose write side and read side run on independent clocks. Words enter on the write clock and leave on the read clock. Pointers cross between the two domains as Gray code through two-flop synchronizers. The full-side flags are computed in the write domain and the empty-side flags in the read domain.

The flag timing is chosen once, at master reset. In standard timing the queue presents an active-low full flag and an active-low empty flag, and a read request loads the next word into the output register. In fall-through timing the queue presents an active-low input-ready flag and an active-low output-valid flag. The oldest stored word moves into the output register without a read request, and a read request consumes it. Programmable almost-full and almost-empty flags compare free space and occupancy against thresholds. These thresholds are loaded from plain input ports by a one-cycle strobe. A partial reset empties the queue but keeps the timing choice and the thresholds. A master reset empties the queue and also restores the default thresholds.

The output drivers are modelled by an enable output. That enable combines a chip-select sampled on the read clock with a combinational output-enable.

Top module: `dcf_queue`

## Requirements
- R1: While `mrst_n` is low at a clock edge, that domain clears its pointers and drives `dout` to 0. It also restores the almost-full threshold to `AF_DEF` and the almost-empty threshold to `AE_DEF` (both 3 by default).
- R2: While `prst_n` is low at a clock edge, that domain clears its pointers and drives `dout` to 0. The timing choice and the loaded thresholds are kept.
- R3: In standard timing, `wflag` is the full flag and `rflag` is the empty flag. `wflag` is 0 when DEPTH words are held and 1 otherwise. `rflag` is 0 when no word is held and 1 otherwise. After reset `wflag`=1 and `rflag`=0.
- R4: In fall-through timing, `wflag` is 0 while storage has room and 1 when storage is full. `rflag` is 0 while `dout` holds a valid word and 1 otherwise. After reset `wflag`=0 and `rflag`=1.
- R5: The timing choice is taken from `mode_sel` (0 = standard, 1 = fall-through) while `mrst_n` is low. It is held, whatever `mode_sel` does, until the next master reset.
- R6: A word on `din` is stored at a rising `wclk` edge when `wen_n` is 0 and storage is not full. A write attempt while full is ignored.
- R7: In standard timing, `ren_n`=0 at a rising `rclk` edge with data held loads the oldest word into `dout`. A read attempt while empty leaves `dout` unchanged.
- R8: In fall-through timing, the oldest word appears on `dout` with no read request. `ren_n`=0 while valid consumes it and presents the next word. `dout` holds steady while valid and not read.
- R9: `af_n` is 0 when free storage is at or below the almost-full threshold. `ae_n` is 0 when occupancy is at or below the almost-empty threshold. In fall-through timing, occupancy counts the word held on `dout`.
- R10: `off_load`=1 at an edge captures `af_off` (write domain) and `ae_off` (read domain). It also forces `af_n`=1 and `ae_n`=0 after that edge, because the flags are not valid while the thresholds change.
- R11: `dout_en` is 1 only when `oe_n` is 0 and `rcs_n` was 0 at the last rising `rclk` edge. Neither input moves the read pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, synchronous in each domain |
| prst_n | input | 1 | Partial reset, active low, synchronous in each domain |
| mode_sel | input | 1 | Timing choice sampled during master reset |
| wen_n | input | 1 | Write enable, active low |
| din | input | DW | Write data |
| ren_n | input | 1 | Read enable, active low |
| rcs_n | input | 1 | Output chip-select, active low, sampled on rclk |
| oe_n | input | 1 | Output enable, active low |
| off_load | input | 1 | Threshold load strobe |
| af_off | input | AW+1 | Almost-full threshold value |
| ae_off | input | AW+1 | Almost-empty threshold value |
| dout | output | DW | Read data register |
| dout_en | output | 1 | Output driver enable |
| wflag | output | 1 | Full (standard) or input-ready (fall-through), active low |
| rflag | output | 1 | Empty (standard) or output-valid (fall-through), active low |
| af_n | output | 1 | Almost-full, active low |
| ae_n | output | 1 | Almost-empty, active low |

## Verification
In fall-through timing, a consume and a refill of `dout` share one read edge. A write and a read can also land on the same pair of edges. The bench holds `ren_n` and `wen_n` low together for one cycle while the queue holds several words. It then judges the result by the exact sequence of words later presented on `dout` and by `rflag` returning high only after the last of them is consumed. A second same-cycle case is a threshold load while the almost flags would otherwise be active; that case is judged by the forced flag values on the following cycle.

// File: rtl/dcf_pkg.sv
// Shared types for the dual-clock queue.
// Assumes nothing beyond a single-bit mode encoding.
package dcf_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } dcf_mode_e;
endpackage

// File: rtl/dcf_sync.sv
// Two-flop synchronizer for a Gray-coded pointer vector.
// Assumes the input changes at most one bit per source clock.
module dcf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    // Two-stage capture into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/dcf_wside.sv
// Write-domain control: write pointer, full and almost-full flags,
// latched timing choice and almost-full threshold.
// Assumes AW >= 2 and that rgs is the read pointer already synchronized to wclk.
module dcf_wside
    import dcf_pkg::*;
#(
    parameter int AW     = 4,
    parameter int AF_DEF = 3
) (
    input  logic          wclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_sel,
    input  logic          wen_n,
    input  logic          off_load,
    input  logic [AW:0]   af_off,
    input  logic [AW:0]   rgs,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          we,
    output logic          wflag,
    output logic          af_n,
    output dcf_mode_e     mode
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [AW:0] wbin, wbin_nxt, wgray_nxt, rbin_s, used, free, afo;
    logic        full_q, full_nxt, af_q, af_hit;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // Next-state pointer and flag terms.
    always_comb begin
        we        = ~wen_n & ~full_q & mrst_n & prst_n;
        wbin_nxt  = wbin + PW'(we);
        wgray_nxt = wbin_nxt ^ (wbin_nxt >> 1);
        full_nxt  = (wgray_nxt == {~rgs[AW:AW-1], rgs[AW-2:0]});
        rbin_s    = g2b(rgs);
        used      = wbin_nxt - rbin_s;
        free      = PW'(DEPTH) - used;
        af_hit    = (free <= afo);
    end

    // Timing choice is captured only during master reset.
    always_ff @(posedge wclk) begin
        if (!mrst_n) mode <= dcf_mode_e'(mode_sel);
    end

    // Almost-full threshold: default on master reset, load on strobe.
    always_ff @(posedge wclk) begin
        if (!mrst_n)       afo <= PW'(AF_DEF);
        else if (off_load) afo <= af_off;
    end

    // Pointer and registered flags; either reset clears them.
    always_ff @(posedge wclk) begin
        if (!mrst_n || !prst_n) begin
            wbin   <= '0;
            wgray  <= '0;
            full_q <= 1'b0;
            af_q   <= 1'b0;
        end else begin
            wbin   <= wbin_nxt;
            wgray  <= wgray_nxt;
            full_q <= full_nxt;
            af_q   <= off_load ? 1'b0 : af_hit;
        end
    end

    assign waddr = wbin[AW-1:0];
    assign wflag = (mode == MODE_FWFT) ? full_q : ~full_q;
    assign af_n  = ~af_q;
endmodule

// File: rtl/dcf_rside.sv
// Read-domain control: read pointer, output register, empty/valid and
// almost-empty flags, latched timing choice, threshold and output enable.
// Assumes wgs is the write pointer already synchronized to rclk and that
// rdata is the storage word at raddr in the same cycle.
module dcf_rside
    import dcf_pkg::*;
#(
    parameter int AW     = 4,
    parameter int DW     = 8,
    parameter int AE_DEF = 3
) (
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_sel,
    input  logic          ren_n,
    input  logic          rcs_n,
    input  logic          oe_n,
    input  logic          off_load,
    input  logic [AW:0]   ae_off,
    input  logic [AW:0]   wgs,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          rflag,
    output logic          ae_n,
    output dcf_mode_e     mode
);
    localparam int PW = AW + 1;
    localparam int CW = AW + 2;

    logic [AW:0]   rbin, rbin_nxt, rgray_nxt, wbin_s, aeo;
    logic [CW-1:0] occ;
    logic          empty_q, valid_q, valid_nxt, ae_q, cs_q;
    logic          fwft, rd_std, take, fill, rinc, ae_hit;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // Read decisions for both timings and the next-state terms.
    always_comb begin
        fwft      = (mode == MODE_FWFT);
        rd_std    = ~fwft & ~ren_n & ~empty_q;
        take      = fwft & ~ren_n & valid_q;
        fill      = fwft & ~empty_q & (~valid_q | take);
        rinc      = rd_std | fill;
        rbin_nxt  = rbin + PW'(rinc);
        rgray_nxt = rbin_nxt ^ (rbin_nxt >> 1);
        valid_nxt = fill | (valid_q & ~take);
        wbin_s    = g2b(wgs);
        occ       = {1'b0, wbin_s - rbin_nxt} + CW'(fwft & valid_nxt);
        ae_hit    = (occ <= {1'b0, aeo});
    end

    // Timing choice is captured only during master reset.
    always_ff @(posedge rclk) begin
        if (!mrst_n) mode <= dcf_mode_e'(mode_sel);
    end

    // Almost-empty threshold: default on master reset, load on strobe.
    always_ff @(posedge rclk) begin
        if (!mrst_n)       aeo <= PW'(AE_DEF);
        else if (off_load) aeo <= ae_off;
    end

    // Chip-select is sampled every read edge.
    always_ff @(posedge rclk) begin
        cs_q <= rcs_n;
    end

    // Pointer, output register and registered flags.
    always_ff @(posedge rclk) begin
        if (!mrst_n || !prst_n) begin
            rbin    <= '0;
            rgray   <= '0;
            empty_q <= 1'b1;
            valid_q <= 1'b0;
            ae_q    <= 1'b1;
            dout    <= '0;
        end else begin
            rbin    <= rbin_nxt;
            rgray   <= rgray_nxt;
            empty_q <= (rgray_nxt == wgs);
            valid_q <= valid_nxt;
            ae_q    <= off_load | ae_hit;
            if (rinc) dout <= rdata;
        end
    end

    assign raddr   = rbin[AW-1:0];
    assign rflag   = fwft ? ~valid_q : ~empty_q;
    assign ae_n    = ~ae_q;
    assign dout_en = ~oe_n & ~cs_q;
endmodule

// File: rtl/dcf_queue.sv
// Dual-clock queue top: storage array, pointer synchronizers and the
// two domain controllers. Assumes both resets are held across at least
// one edge of each clock so that both domains see them.
module dcf_queue
    import dcf_pkg::*;
#(
    parameter int DW     = 8,
    parameter int AW     = 4,
    parameter int AF_DEF = 3,
    parameter int AE_DEF = 3
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_sel,
    input  logic          wen_n,
    input  logic [DW-1:0] din,
    input  logic          ren_n,
    input  logic          rcs_n,
    input  logic          oe_n,
    input  logic          off_load,
    input  logic [AW:0]   af_off,
    input  logic [AW:0]   ae_off,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          wflag,
    output logic          rflag,
    output logic          af_n,
    output logic          ae_n
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   wgray, rgray, wgs, rgs;
    logic          we;
    logic          rst_any_n;
    dcf_mode_e     wmode_q, rmode_q;

    assign rst_any_n = mrst_n & prst_n;

    // Storage write port on the write clock.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= din;
    end

    dcf_sync #(.W(AW + 1)) u_w2r (
        .clk(rclk), .rst_n(rst_any_n), .d(wgray), .q(wgs)
    );

    dcf_sync #(.W(AW + 1)) u_r2w (
        .clk(wclk), .rst_n(rst_any_n), .d(rgray), .q(rgs)
    );

    dcf_wside #(.AW(AW), .AF_DEF(AF_DEF)) u_w (
        .wclk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_sel(mode_sel),
        .wen_n(wen_n), .off_load(off_load), .af_off(af_off), .rgs(rgs),
        .waddr(waddr), .wgray(wgray), .we(we), .wflag(wflag), .af_n(af_n),
        .mode(wmode_q)
    );

    dcf_rside #(.AW(AW), .DW(DW), .AE_DEF(AE_DEF)) u_r (
        .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_sel(mode_sel),
        .ren_n(ren_n), .rcs_n(rcs_n), .oe_n(oe_n), .off_load(off_load),
        .ae_off(ae_off), .wgs(wgs), .rdata(mem[raddr]), .raddr(raddr),
        .rgray(rgray), .dout(dout), .dout_en(dout_en), .rflag(rflag),
        .ae_n(ae_n), .mode(rmode_q)
    );
endmodule

// File: rtl/dcf_queue_chk.sv
// Temporal checks on the queue ports and latched mode, bound to dcf_queue.
// Assumes the mode encoding from dcf_pkg (1 = fall-through).
module dcf_queue_chk #(
    parameter int DW = 8
) (
    input logic          wclk,
    input logic          rclk,
    input logic          mrst_n,
    input logic          prst_n,
    input logic          wen_n,
    input logic          ren_n,
    input logic          rcs_n,
    input logic          off_load,
    input logic [DW-1:0] dout,
    input logic          dout_en,
    input logic          rflag,
    input logic          af_n,
    input logic          ae_n,
    input logic          wmode,
    input logic          rmode
);
    // R1, R2: either reset drives the data output low by the next edge.
    p_reset_dout_low_r2: assert property (@(posedge rclk) disable iff (1'b0)
        (!mrst_n || !prst_n) |=> (dout == '0));

    // R5: the timing choice does not move outside master reset.
    p_mode_held_r5: assert property (@(posedge wclk) disable iff (!mrst_n)
        mrst_n |=> $stable(wmode));

    // R7: a standard-timing read while empty leaves dout alone.
    p_empty_read_ignored_r7: assert property (@(posedge rclk)
        disable iff (!mrst_n || !prst_n)
        (!rmode && !rflag && !ren_n) |=> $stable(dout));

    // R8: a valid fall-through word stays put until it is read.
    p_valid_held_r8: assert property (@(posedge rclk)
        disable iff (!mrst_n || !prst_n)
        (rmode && !rflag && ren_n) |=> (!rflag && $stable(dout)));

    // R10: threshold load masks almost-full.
    p_load_masks_af_r10: assert property (@(posedge wclk)
        disable iff (!mrst_n || !prst_n)
        off_load |=> af_n);

    // R10: threshold load masks almost-empty.
    p_load_masks_ae_r10: assert property (@(posedge rclk)
        disable iff (!mrst_n || !prst_n)
        off_load |=> !ae_n);

    // R11: a deselected chip turns the drivers off after the next edge.
    p_cs_off_r11: assert property (@(posedge rclk) disable iff (!mrst_n)
        rcs_n |=> !dout_en);
endmodule

bind dcf_queue dcf_queue_chk #(.DW(DW)) u_chk (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .wen_n(wen_n), .ren_n(ren_n), .rcs_n(rcs_n), .off_load(off_load),
    .dout(dout), .dout_en(dout_en), .rflag(rflag), .af_n(af_n),
    .ae_n(ae_n), .wmode(wmode_q), .rmode(rmode_q)
);

// File: tb/dcf_queue_test.sv
`timescale 1ns/1ps
// Self-checking bench: vector table walk, then directed reset, flag,
// threshold, fall-through and output-enable tests. Both clocks share
// one 50 MHz source so every latency is deterministic.
module dcf_queue_test;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;
    localparam int NV = 8;
    localparam logic [DW-1:0] VEC [NV] = '{8'h3C, 8'hA5, 8'h00, 8'hFF,
                                           8'h5A, 8'h81, 8'h7E, 8'h19};

    logic clk = 1'b0;
    logic mrst_n = 1'b0, prst_n = 1'b1, mode_sel = 1'b0;
    logic wen_n = 1'b1, ren_n = 1'b1, rcs_n = 1'b1, oe_n = 1'b1, off_load = 1'b0;
    logic [DW-1:0] din = '0;
    logic [AW:0] af_off = '0, ae_off = '0;
    logic [DW-1:0] dout;
    logic dout_en, wflag, rflag, af_n, ae_n;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dcf_queue #(.DW(DW), .AW(AW)) uut (
        .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .mode_sel(mode_sel), .wen_n(wen_n), .din(din), .ren_n(ren_n),
        .rcs_n(rcs_n), .oe_n(oe_n), .off_load(off_load), .af_off(af_off),
        .ae_off(ae_off), .dout(dout), .dout_en(dout_en), .wflag(wflag),
        .rflag(rflag), .af_n(af_n), .ae_n(ae_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [DW-1:0] d);
        wen_n = 1'b0; din = d;
        @(negedge clk);
        wen_n = 1'b1;
    endtask

    task automatic rd();
        ren_n = 1'b0;
        @(negedge clk);
        ren_n = 1'b1;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        mrst_n = 1'b1;
        @(negedge clk);
        // R1 R3: standard reset state
        chk("R3 reset wflag", wflag, 1);
        chk("R3 reset rflag", rflag, 0);
        chk("R1 reset af_n", af_n, 1);
        chk("R1 reset ae_n", ae_n, 0);
        chk("R1 reset dout", dout, 0);

        // Vector table walk: R6 writes, R7 reads in order
        for (int i = 0; i < NV; i++) wr(VEC[i]);
        settle();
        chk("R3 not empty", rflag, 1);
        chk("R9 ae_n at 8 words", ae_n, 1);
        chk("R9 af_n at 8 words", af_n, 1);
        for (int i = 0; i < NV; i++) begin
            rd();
            chk("R7 read data", dout, VEC[i]);
        end
        settle();
        chk("R3 empty again", rflag, 0);
        rd();
        chk("R7 read on empty keeps dout", dout, VEC[NV-1]);

        // R6 fill to full, extra write ignored
        for (int i = 0; i < DEPTH; i++) wr(DW'(8'h40 + i));
        settle();
        chk("R3 full flag", wflag, 0);
        chk("R9 af_n when full", af_n, 0);
        wr(8'hEE);
        for (int i = 0; i < DEPTH; i++) begin
            rd();
            chk("R6 full-fill data", dout, DW'(8'h40 + i));
        end
        settle();
        chk("R6 write while full dropped", rflag, 0);
        chk("R9 ae_n when empty", ae_n, 0);

        // R9 almost-empty boundary with default threshold 3
        for (int i = 0; i < 3; i++) wr(DW'(8'h50 + i));
        settle();
        chk("R9 ae_n at 3 words", ae_n, 0);
        wr(8'h53);
        settle();
        chk("R9 ae_n at 4 words", ae_n, 1);

        // R10 threshold load masks flags, new values take effect
        af_off = 5; ae_off = 1; off_load = 1'b1;
        @(negedge clk);
        off_load = 1'b0;
        chk("R10 af_n masked", af_n, 1);
        chk("R10 ae_n masked", ae_n, 0);
        settle();
        rd(); rd();
        settle();
        chk("R10 ae_n with new threshold at 2 words", ae_n, 1);

        // R2 partial reset in standard timing keeps thresholds
        prst_n = 1'b0;
        @(negedge clk);
        prst_n = 1'b1;
        chk("R2 partial reset rflag", rflag, 0);
        chk("R2 partial reset wflag", wflag, 1);
        chk("R2 partial reset dout", dout, 0);
        for (int i = 0; i < 11; i++) wr(DW'(i));
        settle();
        chk("R2 kept af threshold", af_n, 0);

        // R5 R1 R4 master reset into fall-through
        mrst_n = 1'b0; mode_sel = 1'b1;
        repeat (2) @(negedge clk);
        mrst_n = 1'b1; mode_sel = 1'b0;
        @(negedge clk);
        chk("R4 reset wflag", wflag, 0);
        chk("R4 reset rflag", rflag, 1);
        chk("R1 reset af_n", af_n, 1);
        chk("R1 reset ae_n", ae_n, 0);
        chk("R1 dout cleared", dout, 0);

        // R8 fall-through presentation, R1 default threshold back
        wr(8'h61); wr(8'h62); wr(8'h63);
        settle();
        chk("R8 first word valid", rflag, 0);
        chk("R8 first word shown", dout, 8'h61);
        chk("R1 default ae threshold", ae_n, 0);
        wr(8'h64);
        settle();
        chk("R9 ae_n counts output word", ae_n, 1);
        rd();
        chk("R8 next word after read", dout, 8'h62);
        // same-cycle read and write
        ren_n = 1'b0; wen_n = 1'b0; din = 8'h65;
        @(negedge clk);
        ren_n = 1'b1; wen_n = 1'b1;
        chk("R8 read with write", dout, 8'h63);
        settle();
        rd();
        chk("R8 order 64", dout, 8'h64);
        rd();
        chk("R6 same-cycle write stored", dout, 8'h65);
        rd();
        chk("R4 valid drops when drained", rflag, 1);

        // R4 storage full in fall-through
        for (int i = 0; i < DEPTH + 1; i++) wr(DW'(i));
        settle();
        chk("R4 not ready when full", wflag, 1);
        prst_n = 1'b0;
        @(negedge clk);
        prst_n = 1'b1;
        chk("R2 fall-through kept wflag", wflag, 0);
        chk("R2 fall-through kept rflag", rflag, 1);

        // R11 output enables
        rcs_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        chk("R11 enabled", dout_en, 1);
        rcs_n = 1'b1;
        @(negedge clk);
        chk("R11 chip-select off", dout_en, 0);
        rcs_n = 1'b0;
        @(negedge clk);
        oe_n = 1'b1;
        #1;
        chk("R11 output-enable off", dout_en, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule